// File: doc/BRIEF.md
# Synchronous Bus Master with Wait States

This block connects a host to a shared system bus that uses a clock for all timing and keeps address and data on separate wires. The host hands it one command at a time: a single-word read, a single-word write, or a multi-beat read that fills a cache line. The master asks an external arbiter for the bus, waits until the arbiter grants it, runs the transfer, then lets go of the bus. It hands each read word back to the host and raises a one-cycle completion pulse.

Single reads and writes are paced by the slave. The master holds address and controls steady through any number of wait cycles until the slave raises ready. Line reads are paced by the clock alone. The address is shown once, and the slave then returns one word per cycle after a fixed lead-in. With the default lead-in of three cycles, the first word lands in the fourth cycle of the transfer. Moving x bytes over the 64-bit path therefore takes 8x/64 word cycles plus the lead-in.

Top module: `bus_master_sync`

## Requirements
- R1: While reset is held and in the first cycle after it, cmdReady is 1. busReq, busAddrEn, busDataEn, busRd, busWr, done and rdValid are 0.
- R2: cmdReady is 1 only when the master is idle. A command is taken when cmdValid and cmdReady are both 1. A command offered while cmdReady is 0 is ignored and starts no transfer. cmdKind encodes 2'b00 single read, 2'b01 single write and 2'b10 line read.
- R3: busReq rises in the cycle after a command is taken and stays high while busGnt is low. No address, data, read or write strobe is driven until busGnt has been sampled high at a clock edge during the request phase.
- R4: For a single read, the cycle after the grant is sampled shows busAddrEn=1, busRd=1 and the command address. At the edge where busReady is 1, busRdata is captured. The word appears on rdData with rdValid=1 in the next cycle.
- R5: For a single write, the cycle after the grant is sampled shows busAddrEn=1, busDataEn=1 and busWr=1, with the command address and write word. The write completes at the edge where busReady is 1.
- R6: In a single transfer, while busReady is 0 the master holds its address, data and strobes unchanged, for any number of wait cycles.
- R7: A line read drives the address (busAddrEn=1) only in its first cycle. busRd stays 1 from that cycle until the last word. busReady has no effect on it.
- R8: The line length is cmdBeats. A value of 0 is treated as 1, and values above 8 are treated as 8.
- R9: The cycle after the final word, or after the ready edge, shows done=1 for exactly one cycle. In that cycle busReq, busRd, busWr and both enables are 0. The master is idle (cmdReady=1) in the next cycle.
- R10: In a line read of n words, counting its address cycle as cycle 1, words are sampled in cycles 4 to 3+n. They appear on rdData with rdValid=1 in cycles 5 to 4+n, in order. The last word coincides with done.
- R11: busAddr reads 0 whenever busAddrEn is 0, and busWdata reads 0 whenever busDataEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Host offers a command |
| cmdReady | output | 1 | Master is idle and takes a command |
| cmdKind | input | 2 | 00 read, 01 write, 10 line read; 11 behaves as a read |
| cmdAddr | input | 32 | Transfer address |
| cmdWdata | input | 64 | Word for a single write |
| cmdBeats | input | 4 | Words in a line read (clamped to 1..8) |
| rdData | output | 64 | Read word returned to the host |
| rdValid | output | 1 | rdData holds a new word this cycle |
| done | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Request for bus ownership |
| busGnt | input | 1 | Grant from the arbiter |
| busAddr | output | 32 | Address lines (0 when not driven) |
| busAddrEn | output | 1 | Address driver enable |
| busRd | output | 1 | Read control |
| busWr | output | 1 | Write control |
| busWdata | output | 64 | Write data lines (0 when not driven) |
| busDataEn | output | 1 | Data driver enable |
| busRdata | input | 64 | Read data from the slave |
| busReady | input | 1 | Slave ready for single transfers |

## Verification
The assertions assume that the arbiter keeps busGnt high from the grant until the completion pulse. They also assume that the lead-in parameter is at least two. The stimulus respects both: the bench raises the grant only after a random delay, keeps it high through the transfer, and drops it on the completion cycle. busReady and busRdata are driven randomly outside the slots where they matter, so a line read never depends on them. Random commands are offered while the master is busy, to show that they are ignored.

// File: rtl/bmst_pkg.sv
`timescale 1ns/1ps
package bmst_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_STORE = 2'b01,
    KIND_BLOCK = 2'b10,
    KIND_RSVD  = 2'b11
  } kind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic latchCmd;
    logic capture;
    logic driveAddr;
    logic driveData;
  } dpStrobe_t;

endpackage

// File: rtl/bmst_ctrl.sv
`timescale 1ns/1ps
module bmst_ctrl
  import bmst_pkg::*;
#(
  parameter int MAX_BEATS   = 8,
  parameter int BEAT_W      = 4,
  parameter int LEAD_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdKind,
  input  logic [BEAT_W-1:0] cmdBeats,
  input  logic              busGnt,
  input  logic              busReady,
  output logic              cmdReady,
  output logic              busReq,
  output logic              busRd,
  output logic              busWr,
  output logic              done,
  output dpStrobe_t         strobe
);

  localparam int LAT_WAIT = LEAD_CYCLES - 1;
  localparam int LAT_W    = $clog2(LEAD_CYCLES + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ACC, ST_BADDR, ST_BLAT, ST_BDATA, ST_FIN
  } state_e;

  state_e            state, stateNxt;
  kind_e             kindReg;
  logic [BEAT_W-1:0] beatsLeft;
  logic [LAT_W-1:0]  latCnt;
  logic              isStore, isBlock;

  function automatic logic [BEAT_W-1:0] clampBeats(input logic [BEAT_W-1:0] b);
    if (b == '0)                          return BEAT_W'(1);
    else if (b > BEAT_W'(MAX_BEATS))      return BEAT_W'(MAX_BEATS);
    else                                  return b;
  endfunction

  assign isStore = (kindReg == KIND_STORE);
  assign isBlock = (kindReg == KIND_BLOCK);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (cmdValid) stateNxt = ST_REQ;
      ST_REQ:   if (busGnt) stateNxt = isBlock ? ST_BADDR : ST_ACC;
      ST_ACC:   if (busReady) stateNxt = ST_FIN;
      ST_BADDR: stateNxt = ST_BLAT;
      ST_BLAT:  if (latCnt == '0) stateNxt = ST_BDATA;
      ST_BDATA: if (beatsLeft == BEAT_W'(1)) stateNxt = ST_FIN;
      ST_FIN:   stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kindReg   <= KIND_FETCH;
      beatsLeft <= '0;
      latCnt    <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && cmdValid) begin
        kindReg   <= kind_e'(cmdKind);
        beatsLeft <= clampBeats(cmdBeats);
      end
      if (state == ST_BADDR) latCnt <= LAT_W'(LAT_WAIT - 1);
      else if (state == ST_BLAT && latCnt != '0) latCnt <= latCnt - LAT_W'(1);
      if (state == ST_BDATA) beatsLeft <= beatsLeft - BEAT_W'(1);
    end
  end

  always_comb begin
    cmdReady = (state == ST_IDLE);
    done     = (state == ST_FIN);
    busReq   = (state == ST_REQ) || (state == ST_ACC) || (state == ST_BADDR) ||
               (state == ST_BLAT) || (state == ST_BDATA);
    busRd    = ((state == ST_ACC) && !isStore) || (state == ST_BADDR) ||
               (state == ST_BLAT) || (state == ST_BDATA);
    busWr    = (state == ST_ACC) && isStore;
    strobe.latchCmd  = (state == ST_IDLE) && cmdValid;
    strobe.capture   = ((state == ST_ACC) && busReady && !isStore) || (state == ST_BDATA);
    strobe.driveAddr = (state == ST_ACC) || (state == ST_BADDR);
    strobe.driveData = (state == ST_ACC) && isStore;
  end

  AST_START_AFTER_GNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRd || busWr) |-> ($past(busGnt) && $past(busReq))); // R3
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !busReq); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACC && !busReady) |=> (state == ST_ACC)); // R6
  AST_ADDR_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.driveAddr && isBlock) |=> (!strobe.driveAddr && busRd)); // R7
  AST_BEATS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BDATA) |-> (beatsLeft != '0 && beatsLeft <= BEAT_W'(MAX_BEATS))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && cmdReady)); // R9
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busReq && !busRd && !busWr)); // R9

endmodule

// File: rtl/bmst_datapath.sv
`timescale 1ns/1ps
module bmst_datapath
  import bmst_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdWdata,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] busAddr,
  output logic          busAddrEn,
  output logic [DW-1:0] busWdata,
  output logic          busDataEn,
  output logic [DW-1:0] rdData,
  output logic          rdValid
);

  logic [AW-1:0] addrReg;
  logic [DW-1:0] wdataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobe.latchCmd) begin
        addrReg  <= cmdAddr;
        wdataReg <= cmdWdata;
      end
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= busRdata;
    end
  end

  assign busAddrEn = strobe.driveAddr;
  assign busDataEn = strobe.driveData;
  assign busAddr   = strobe.driveAddr ? addrReg  : '0;
  assign busWdata  = strobe.driveData ? wdataReg : '0;

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.driveAddr && $past(strobe.driveAddr)) |-> $stable(busAddr)); // R6
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.driveData && $past(strobe.driveData)) |-> $stable(busWdata)); // R6

endmodule

// File: rtl/bus_master_sync.sv
`timescale 1ns/1ps
module bus_master_sync
  import bmst_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 64,
  parameter int MAX_BEATS   = 8,
  parameter int LEAD_CYCLES = 3,
  parameter int BEAT_W      = $clog2(MAX_BEATS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdKind,
  input  logic [AW-1:0]     cmdAddr,
  input  logic [DW-1:0]     cmdWdata,
  input  logic [BEAT_W-1:0] cmdBeats,
  output logic [DW-1:0]     rdData,
  output logic              rdValid,
  output logic              done,
  output logic              busReq,
  input  logic              busGnt,
  output logic [AW-1:0]     busAddr,
  output logic              busAddrEn,
  output logic              busRd,
  output logic              busWr,
  output logic [DW-1:0]     busWdata,
  output logic              busDataEn,
  input  logic [DW-1:0]     busRdata,
  input  logic              busReady
);

  dpStrobe_t strobe;

  bmst_ctrl #(
    .MAX_BEATS(MAX_BEATS), .BEAT_W(BEAT_W), .LEAD_CYCLES(LEAD_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdBeats(cmdBeats), .busGnt(busGnt), .busReady(busReady),
    .cmdReady(cmdReady), .busReq(busReq), .busRd(busRd), .busWr(busWr),
    .done(done), .strobe(strobe)
  );

  bmst_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdWdata(cmdWdata), .busRdata(busRdata), .busAddr(busAddr),
    .busAddrEn(busAddrEn), .busWdata(busWdata), .busDataEn(busDataEn),
    .rdData(rdData), .rdValid(rdValid)
  );

  AST_DRIVE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    (busAddrEn || busDataEn) |-> busReq); // R3

endmodule

// File: tb/sim_bus_master_sync.sv
`timescale 1ns/1ps
module sim_bus_master_sync;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdKind = 2'b00;
  logic [31:0] cmdAddr = '0;
  logic [63:0] cmdWdata = '0;
  logic [3:0]  cmdBeats = '0;
  logic [63:0] rdData;
  logic        rdValid, done, busReq;
  logic        busGnt = 1'b0;
  logic [31:0] busAddr;
  logic        busAddrEn, busRd, busWr, busDataEn;
  logic [63:0] busWdata;
  logic [63:0] busRdata = '0;
  logic        busReady = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  bus_master_sync u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdWdata(cmdWdata), .cmdBeats(cmdBeats),
    .rdData(rdData), .rdValid(rdValid), .done(done), .busReq(busReq),
    .busGnt(busGnt), .busAddr(busAddr), .busAddrEn(busAddrEn), .busRd(busRd),
    .busWr(busWr), .busWdata(busWdata), .busDataEn(busDataEn),
    .busRdata(busRdata), .busReady(busReady)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] beatVal(input logic [31:0] a, input int i);
    return {a ^ 32'hA5A5_0000, a + 32'(i) * 32'h0101_0101};
  endfunction

  function automatic int effBeats(input int b);
    if (b == 0) return 1;
    if (b > 8) return 8;
    return b;
  endfunction

  task automatic doXfer(input logic [1:0] kind, input logic [31:0] addr,
                        input logic [63:0] wdata, input int beats,
                        input int gntDelay, input int waits, input bit junk);
    bit isStore = (kind == 2'b01);
    bit isBlock = (kind == 2'b10);
    logic [63:0] fv = {addr, ~addr};
    int n = effBeats(beats);
    @(negedge clk);
    check("R2 cmdReady idle", cmdReady, 1);
    cmdValid = 1'b1; cmdKind = kind; cmdAddr = addr; cmdWdata = wdata;
    cmdBeats = 4'(beats);
    @(negedge clk);
    if (junk) begin
      cmdAddr = ~addr; cmdKind = 2'($urandom_range(2, 0)); cmdBeats = 4'($urandom);
    end else cmdValid = 1'b0;
    for (int k = 0; k <= gntDelay; k++) begin
      if (k > 0) @(negedge clk);
      check("R3 request held", busReq, 1);
      check("R3 nothing driven", {busAddrEn, busDataEn, busRd, busWr}, 0);
      check("R2 busy not ready", cmdReady, 0);
      busGnt = (k == gntDelay);
    end
    if (!isBlock) begin
      for (int w = 0; w <= waits; w++) begin
        @(negedge clk);
        check("R4 R5 R6 addr", busAddr, addr);
        check("R4 R5 R6 strobes", {busAddrEn, busRd, busWr, busDataEn},
              {1'b1, !isStore, isStore, isStore});
        check("R5 R6 R11 wdata", busWdata, isStore ? wdata : 64'd0);
        busReady = (w == waits);
        busRdata = (w == waits) ? fv : {$urandom, $urandom};
      end
    end else begin
      @(negedge clk);
      check("R7 addr cycle", {busAddrEn, busRd, busWr, busDataEn}, 4'b1100);
      check("R7 addr value", busAddr, addr);
      busReady = 1'($urandom);
      for (int c = 2; c <= 3 + n; c++) begin
        @(negedge clk);
        check("R7 addr once", {busAddrEn, busRd, busReq}, 3'b011);
        check("R11 addr quiet", busAddr, 0);
        check("R10 rdValid", rdValid, (c >= 5));
        if (c >= 5) check("R10 beat order", rdData, beatVal(addr, c - 5));
        busRdata = (c >= 4) ? beatVal(addr, c - 4) : {$urandom, $urandom};
        busReady = 1'($urandom);
      end
    end
    @(negedge clk);
    busGnt = 1'b0; busReady = 1'b0; cmdValid = 1'b0;
    check("R9 done", done, 1);
    check("R9 released", {busReq, busAddrEn, busDataEn, busRd, busWr}, 0);
    check("R11 quiet", {busAddr, busWdata[31:0]}, 0);
    if (isBlock) begin
      check("R8 R10 last beat", {rdValid, rdData}, {1'b1, beatVal(addr, n - 1)});
    end else if (!isStore) begin
      check("R4 read word", {rdValid, rdData}, {1'b1, fv});
    end else begin
      check("R5 no read word", rdValid, 0);
    end
    @(negedge clk);
    check("R9 done once", done, 0);
    check("R9 idle again", cmdReady, 1);
    check("R2 no extra transfer", busReq, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {cmdReady, busReq, busAddrEn, busDataEn, busRd, busWr, done, rdValid},
          8'b1000_0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {cmdReady, busReq, busAddrEn, busDataEn, busRd, busWr, done, rdValid},
          8'b1000_0000);
    // directed corners
    doXfer(2'b00, 32'h1000_0040, 64'd0, 1, 0, 0, 0);
    doXfer(2'b01, 32'h2000_0080, 64'hDEAD_BEEF_0123_4567, 1, 2, 3, 0);
    doXfer(2'b00, 32'h3000_00C0, 64'd0, 1, 3, 4, 1);
    doXfer(2'b10, 32'h4000_0100, 64'd0, 1, 0, 0, 0);
    doXfer(2'b10, 32'h5000_0140, 64'd0, 8, 1, 0, 0);
    doXfer(2'b10, 32'h6000_0180, 64'd0, 0, 0, 0, 0);  // R8 zero -> 1
    doXfer(2'b10, 32'h7000_01C0, 64'd0, 13, 2, 0, 1); // R8 13 -> 8
    // random mix
    for (int t = 0; t < 80; t++) begin
      doXfer(2'($urandom_range(2, 0)), $urandom, {$urandom, $urandom},
             int'($urandom_range(15, 0)), int'($urandom_range(3, 0)),
             int'($urandom_range(4, 0)), 1'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule